// File: doc/BRIEF.md
# Stereo Sample FIFO with Paced DMA Request

This block buffers stereo audio ahead of a pair of channel paths. Each bus write carries one stereo pair packed into a 32-bit word: two signed 16-bit samples, left in the low half and right in the high half. The words enter a 32-entry first-in first-out store. A sample strobe from the downstream rate generator takes one word out and presents it on the left and right channel outputs. A channel-swap control and a separate enable for each channel act on those outputs.

A DMA request line asks the transfer engine for more data whenever the fill level is at or below a programmable threshold. After the request drops, a programmable dwell time keeps it low before it may rise again. This stops the request from toggling every cycle near the threshold. The block has a flush command with a completion flag and a sticky flag for writes lost to a full store. When the peripheral enable is low, the whole store is held empty.

Top module: `sample_fifo_dreq`

## Requirements
- R1: While `rst_n` is low, and one cycle after any edge at which `periph_en` was low, `level` is 0, both channel outputs are 0, `overflow` is 0 and `dreq` is 0 (one edge later for `dreq`).
- R2: A write (`wr_en` high, store not full, `periph_en` high, `flush` low) raises `level` by one after the edge. `wr_data[15:0]` is the left sample and `wr_data[31:16]` is the right sample.
- R3: A write while `level` is 32 is dropped and sets `overflow`. `overflow` stays set until an edge at which `flush` is high or `periph_en` is low.
- R4: A `sample_tick` with `level` above 0 removes the oldest word and shows it on the channel outputs after that edge, in write order.
- R5: A `sample_tick` with the store empty changes nothing: the channel outputs keep the last removed pair and `level` stays 0.
- R6: With `swap_lr` high, `left_out` shows the right sample and `right_out` shows the left sample. The effect is immediate and does not touch the store.
- R7: With `left_en` low, `left_out` is 0. With `right_en` low, `right_out` is 0.
- R8: Without dwell hold-off, `dreq` is high in the cycle after an edge at which `dreq_en` was high, the block was enabled and not flushing, and `level <= threshold` held.
- R9: Once `dreq` falls, it stays low for at least `dwell`+1 cycles, where `dwell` is the value sampled at the falling edge.
- R10: An edge with `flush` high empties the store. `flush_done` rises after the second consecutive edge with `flush` high and falls after the first edge with `flush` low.
- R11: A write and a sample tick at the same edge, with the store neither empty nor full, leave `level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_en | input | 1 | Peripheral enable; store is held empty while low |
| flush | input | 1 | Flush command, level sensitive |
| dreq_en | input | 1 | Enables the DMA request |
| swap_lr | input | 1 | Exchanges left and right outputs |
| left_en | input | 1 | Left channel enable |
| right_en | input | 1 | Right channel enable |
| threshold | input | 6 | Request asserted at or below this fill level |
| dwell | input | 5 | Hold-off cycles after request deassertion |
| wr_en | input | 1 | Bus write strobe into the store |
| wr_data | input | 32 | Stereo pair: [15:0] left, [31:16] right |
| sample_tick | input | 1 | Sample strobe, removes one word |
| left_out | output | 16 | Left channel sample |
| right_out | output | 16 | Right channel sample |
| dreq | output | 1 | DMA request |
| flush_done | output | 1 | Flush completion flag |
| overflow | output | 1 | Sticky lost-write flag |
| level | output | 6 | Current fill level |

## Verification
The assertions check on every cycle that the fill level never exceeds the depth, that the store is empty after a disabled or flushing edge, and that overflow is sticky. They also check that a request only follows a cycle with the level at or below the threshold, that the dwell counter keeps the request low, that flush-done only follows a flush, and that the held pair does not move while the store is empty. Only the bench scenarios can show the exact word order through the store, the swap and enable routing, and the measured length of the dwell gap. The same holds for the full-store drop and for a simultaneous write and tick. The bench compares these against a reference model it updates every cycle under random traffic.

// File: rtl/sfifo_pkg.sv
`timescale 1ns/1ps
package sfifo_pkg;
    localparam int SAMPLE_W = 16;
    localparam int WORD_W   = 2 * SAMPLE_W;

    // One bus word: left sample in the low half, right sample in the high half
    typedef struct packed {
        logic [SAMPLE_W-1:0] right;
        logic [SAMPLE_W-1:0] left;
    } stereo_t;
endpackage

// File: rtl/sfifo_store.sv
`timescale 1ns/1ps
module sfifo_store #(
    parameter int DEPTH  = 32,
    parameter int WORD_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           push,
    input  logic                           pop,
    input  logic [WORD_W-1:0]              wdata,
    output logic [WORD_W-1:0]              rdata,
    output logic [$clog2(DEPTH+1)-1:0]     count,
    output logic                           full,
    output logic                           empty,
    output logic                           popped
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_s;

    ptr_s q, d;
    logic [WORD_W-1:0] mem [DEPTH];
    logic push_ok, pop_ok;

    assign full    = (q.cnt == CW'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign push_ok = push && !full && !clr;
    assign pop_ok  = pop && !empty && !clr;
    assign rdata   = mem[q.rp];
    assign count   = q.cnt;
    assign popped  = pop_ok;

    always_comb begin
        d = q;
        if (clr) begin
            d = '0;
        end else begin
            if (push_ok) d.wp = (q.wp == LAST) ? '0 : q.wp + 1'b1;
            if (pop_ok)  d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
            d.cnt = q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[q.wp] <= wdata;
    end

    // R3: fill level never passes the depth
    a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/sfifo_pacer.sv
`timescale 1ns/1ps
module sfifo_pacer #(
    parameter int DWELL_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               arm,
    input  logic [DWELL_W-1:0] dwell,
    output logic               dreq
);
    typedef struct packed {
        logic               req;
        logic [DWELL_W-1:0] dw;
    } pace_s;

    pace_s q, d;

    always_comb begin
        d = q;
        if (q.req) begin
            if (!arm) begin
                d.req = 1'b0;
                d.dw  = dwell;
            end
        end else if (q.dw != '0) begin
            d.dw = q.dw - 1'b1;
        end else begin
            d.req = arm;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dreq = q.req;

    // R9: request stays low while the hold-off is still counting
    a_r9_dwell_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.req && q.dw != '0) |=> !q.req);
endmodule

// File: rtl/sample_fifo_dreq.sv
`timescale 1ns/1ps
module sample_fifo_dreq #(
    parameter int DEPTH   = 32,
    parameter int THR_W   = 6,
    parameter int DWELL_W = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              periph_en,
    input  logic                              flush,
    input  logic                              dreq_en,
    input  logic                              swap_lr,
    input  logic                              left_en,
    input  logic                              right_en,
    input  logic [THR_W-1:0]                  threshold,
    input  logic [DWELL_W-1:0]                dwell,
    input  logic                              wr_en,
    input  logic [sfifo_pkg::WORD_W-1:0]      wr_data,
    input  logic                              sample_tick,
    output logic [sfifo_pkg::SAMPLE_W-1:0]    left_out,
    output logic [sfifo_pkg::SAMPLE_W-1:0]    right_out,
    output logic                              dreq,
    output logic                              flush_done,
    output logic                              overflow,
    output logic [$clog2(DEPTH+1)-1:0]        level
);
    import sfifo_pkg::*;

    typedef struct packed {
        stereo_t hold;
        logic    ovf;
        logic    fl;
        logic    fd;
    } top_s;

    top_s q, d;
    logic clr, full, empty, popped, arm;
    logic [WORD_W-1:0] rdata;

    assign clr = !periph_en || flush;

    sfifo_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .push(wr_en), .pop(sample_tick), .wdata(wr_data),
        .rdata(rdata), .count(level), .full(full), .empty(empty),
        .popped(popped)
    );

    assign arm = dreq_en && !clr && (32'(level) <= 32'(threshold));

    sfifo_pacer #(.DWELL_W(DWELL_W)) u_pacer (
        .clk(clk), .rst_n(rst_n), .arm(arm), .dwell(dwell), .dreq(dreq)
    );

    always_comb begin
        d = q;
        if (!periph_en)  d.hold = '0;
        else if (popped) d.hold = stereo_t'(rdata);
        d.ovf = clr ? 1'b0 : (q.ovf | (wr_en & full));
        d.fl  = flush;
        d.fd  = flush & q.fl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign left_out   = !left_en  ? '0 : (swap_lr ? q.hold.right : q.hold.left);
    assign right_out  = !right_en ? '0 : (swap_lr ? q.hold.left  : q.hold.right);
    assign overflow   = q.ovf;
    assign flush_done = q.fd;

    // R1: a disabled edge leaves the store empty and the flag clear
    a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !periph_en |=> (level == '0 && !overflow));
    // R3: overflow is sticky while enabled and not flushing
    a_r3_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && periph_en && !flush) |=> overflow);
    // R8: a request follows a cycle at or below the threshold
    a_r8_dreq_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> $past(dreq_en && 32'(level) <= 32'(threshold)));
    // R10: flush empties the store, and done only follows a flush
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> level == '0);
    a_r10_done_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush_done |-> $past(flush));
    // R5: an empty store keeps the held pair
    a_r5_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en && empty) |=> $stable(q.hold));
endmodule

// File: tb/sim_sample_fifo_dreq.sv
`timescale 1ns/1ps
module sim_sample_fifo_dreq;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, periph_en, flush, dreq_en, swap_lr, left_en, right_en;
    logic [5:0] threshold;
    logic [4:0] dwell;
    logic wr_en, sample_tick;
    logic [31:0] wr_data;
    logic [15:0] left_out, right_out;
    logic dreq, flush_done, overflow;
    logic [5:0] level;

    sample_fifo_dreq u0 (
        .clk(clk), .rst_n(rst_n), .periph_en(periph_en), .flush(flush),
        .dreq_en(dreq_en), .swap_lr(swap_lr), .left_en(left_en), .right_en(right_en),
        .threshold(threshold), .dwell(dwell), .wr_en(wr_en), .wr_data(wr_data),
        .sample_tick(sample_tick), .left_out(left_out), .right_out(right_out),
        .dreq(dreq), .flush_done(flush_done), .overflow(overflow), .level(level)
    );

    // reference state, from the requirements
    bit [31:0] mq[$];
    bit [31:0] m_hold;
    bit m_ovf, m_req, m_fd, m_fl;
    int m_dw;
    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;

    task automatic chk(string tag, int got, int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic int exp_left();
        if (!left_en) return 0;
        return swap_lr ? int'(m_hold[31:16]) : int'(m_hold[15:0]);
    endfunction

    function automatic int exp_right();
        if (!right_en) return 0;
        return swap_lr ? int'(m_hold[15:0]) : int'(m_hold[31:16]);
    endfunction

    task automatic model_edge();
        bit clr, full, arm;
        int sz;
        if (!rst_n) begin
            mq.delete(); m_hold = 0; m_ovf = 0; m_req = 0; m_fd = 0; m_fl = 0; m_dw = 0;
            return;
        end
        sz   = mq.size();
        clr  = !periph_en || flush;
        full = (sz == 32);
        arm  = dreq_en && !clr && (sz <= int'(threshold));
        if (m_req) begin
            if (!arm) begin m_req = 0; m_dw = int'(dwell); end
        end else if (m_dw != 0) m_dw--;
        else m_req = arm;
        m_ovf = clr ? 1'b0 : (m_ovf | (wr_en & full));
        m_fd  = flush & m_fl;
        m_fl  = flush;
        if (clr) mq.delete();
        else begin
            if (sample_tick && sz != 0) m_hold = mq.pop_front();
            if (wr_en && !full) mq.push_back(wr_data);
        end
        if (!periph_en) m_hold = 0;
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk("R2 level", int'(level), mq.size());
        chk("R4 left", int'(left_out), exp_left());
        chk("R4 right", int'(right_out), exp_right());
        chk("R8 dreq", int'(dreq), int'(m_req));
        chk("R3 overflow", int'(overflow), int'(m_ovf));
        chk("R10 flush_done", int'(flush_done), int'(m_fd));
    endtask

    task automatic push_word(input bit [31:0] w);
        wr_en = 1; wr_data = w; step(); wr_en = 0;
    endtask

    task automatic tick();
        sample_tick = 1; step(); sample_tick = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            nfail++;
            $display("FAIL watchdog: got %0d cycles expected < 150000", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int lowcnt;
        void'($urandom(32'h5EED_0A17));
        rst_n = 0; periph_en = 0; flush = 0; dreq_en = 0; swap_lr = 0;
        left_en = 1; right_en = 1; threshold = 6'd16; dwell = 5'd2;
        wr_en = 0; wr_data = 0; sample_tick = 0;
        repeat (3) step();
        // R1: reset state
        chk("R1 level", int'(level), 0);
        chk("R1 dreq", int'(dreq), 0);
        chk("R1 left", int'(left_out), 0);
        rst_n = 1;
        wr_en = 1; wr_data = 32'h1111_2222; step(); wr_en = 0;
        chk("R1 write ignored while disabled", int'(level), 0);

        periph_en = 1; dreq_en = 1;
        push_word(32'hAAAA_0001);
        push_word(32'hBBBB_0002);
        push_word(32'hCCCC_0003);
        chk("R2 level after three writes", int'(level), 3);
        tick();
        chk("R4 first left", int'(left_out), 16'h0001);
        chk("R4 first right", int'(right_out), 16'hAAAA);
        // R6: swap at the outputs
        swap_lr = 1; #1;
        chk("R6 swapped left", int'(left_out), 16'hAAAA);
        chk("R6 swapped right", int'(right_out), 16'h0001);
        swap_lr = 0;
        // R7: channel enables
        left_en = 0; #1;
        chk("R7 left disabled", int'(left_out), 0);
        chk("R7 right still on", int'(right_out), 16'hAAAA);
        left_en = 1; right_en = 0; #1;
        chk("R7 right disabled", int'(right_out), 0);
        right_en = 1;
        // R11: simultaneous write and tick
        wr_en = 1; wr_data = 32'hDDDD_0004; sample_tick = 1; step();
        wr_en = 0; sample_tick = 0;
        chk("R11 level unchanged", int'(level), 2);
        chk("R4 second left", int'(left_out), 16'h0002);
        tick(); tick();
        chk("R4 fourth left", int'(left_out), 16'h0004);
        // R5: underrun holds
        tick(); tick();
        chk("R5 hold left", int'(left_out), 16'h0004);
        chk("R5 hold right", int'(right_out), 16'hDDDD);
        chk("R5 level", int'(level), 0);
        // R3: fill past full
        for (int i = 0; i < 33; i++) push_word(32'h0100_0000 + 32'(i));
        chk("R3 level at full", int'(level), 32);
        chk("R3 overflow set", int'(overflow), 1);
        tick();
        chk("R3 oldest kept", int'(left_out), 0);
        step(); step();
        chk("R3 overflow sticky", int'(overflow), 1);
        // R10: flush handshake
        flush = 1; step();
        chk("R10 emptied", int'(level), 0);
        chk("R10 done not yet", int'(flush_done), 0);
        step();
        chk("R10 done set", int'(flush_done), 1);
        chk("R3 overflow cleared by flush", int'(overflow), 0);
        flush = 0; step();
        chk("R10 done cleared", int'(flush_done), 0);
        // R9: dwell hold-off
        threshold = 6'd0; dwell = 5'd5;
        repeat (8) step();
        chk("R8 request at empty", int'(dreq), 1);
        push_word(32'h0);
        sample_tick = 1; step(); sample_tick = 0;
        lowcnt = 0;
        while (!dreq && lowcnt < 100) begin lowcnt++; step(); end
        chk("R9 low cycles", lowcnt, 6);

        // random traffic
        for (int seg = 0; seg < 30; seg++) begin
            int wbias = int'($urandom % 100);
            threshold = 6'($urandom % 40);
            dwell = 5'($urandom);
            for (int k = 0; k < 100; k++) begin
                periph_en   = ($urandom % 80) != 0;
                flush       = ($urandom % 60) == 0;
                dreq_en     = ($urandom % 20) != 0;
                swap_lr     = ($urandom % 2) == 1;
                left_en     = ($urandom % 8) != 0;
                right_en    = ($urandom % 8) != 0;
                wr_en       = int'($urandom % 100) < wbias;
                wr_data     = $urandom;
                sample_tick = ($urandom % 2) == 1;
                step();
            end
        end
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule